// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a simple internal request port and an external asynchronous static RAM with a 20-bit address and a 4-bit bidirectional data bus. A requester pulses `start` with a direction flag, an address and write data. The controller then drives the active-low chip-enable, output-enable and write-enable strobes and steers the enable of an external tristate data driver. When the access is over, it returns a one-cycle `done` pulse and, for reads, registered read data.

The memory's nanosecond rules become whole clock-cycle counts. Each count is computed from a clock-period parameter, rounded up, with at least one cycle per phase. A read phase covers both the address-to-data time and the minimum cycle time. A write phase covers the longest of four limits: the write-enable pulse width, the address setup to write end, the data setup to write end, and the write cycle time. By default, output-enable is high during writes. A write that directly follows a read first waits out the memory's output turn-off. In the alternative mode, output-enable stays low during writes. The write-enable pulse is then lengthened: for the first part of it the driver stays off while the memory releases the bus, and the data setup window follows.

The default figures assume an 8 ns clock. With those figures a read holds the strobes low for 2 cycles, a write holds write-enable low for 2 cycles, and the turnaround takes 1 cycle.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `done` is 0, and they stay so until the first `start`.
- R2: A `start` with `req_write`=0 accepted in idle drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly 2 cycles at the default timing. In the last of those cycles it captures `mem_dq_in` into `rdata`. `done` is seen 3 sampled cycles after the start edge.
- R3: A `start` with `req_write`=1 from idle, or after a write, drives `mem_ce_n`=0 and `mem_we_n`=0 for exactly 2 cycles with `mem_oe_n`=1. `mem_dq_oe`=1 and `mem_dq_out` equals the write data in both cycles. `done` follows 3 sampled cycles after the start edge.
- R4: A write that directly follows a read inserts one extra turnaround cycle with all strobes high and the driver off. The driver is enabled only after `mem_oe_n` has been 1 for at least one full cycle, so `done` arrives after 4 cycles and the first driven cycle is the second.
- R5: `mem_dq_oe` is 1 only while both `mem_ce_n` and `mem_we_n` are 0.
- R6: `done` is a single-cycle pulse. `rdata` keeps the last read value across later writes.
- R7: A `start` seen while an access is in progress is ignored: no second access follows, and the memory word it names is left unchanged.
- R8: With `OE_LOW_WRITE`=1, `mem_oe_n` stays 0 during writes and `mem_we_n` is 0 for 2 cycles. The driver is off in the first of those cycles and on in the second.
- R9: `mem_addr` holds the accepted request address and is stable for every cycle in which `mem_ce_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Request address |
| req_wdata | input | 4 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 4 | Registered read data |
| mem_addr | output | 20 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 4 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable of the data driver |
| mem_dq_in | input | 4 | Data from the memory |

## Verification
A corrupted phase counter shows up at once as a strobe window of the wrong length: one cycle too many or too few of low chip-enable or write-enable, and `done` arriving early or late in that same access. A wrong turnaround flag shows up at the first write after a read, where the driver turns on in the first write cycle instead of the second. A wrong driver enable shows up as drive outside the window where chip-enable and write-enable are both low, or as wrong data captured by the memory, which the next read of that word exposes. A lost idle state shows up as a second access, or an overwritten word, after an ignored `start`.

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int AW           = 20,
  parameter int DW           = 4,
  parameter int CLK_PS       = 8000,
  parameter int T_AA_PS      = 10000,
  parameter int T_RC_PS      = 10000,
  parameter int T_WC_PS      = 10000,
  parameter int T_PWE_PS     = 7000,
  parameter int T_AW_PS      = 7000,
  parameter int T_SD_PS      = 5000,
  parameter int T_HZWE_PS    = 5000,
  parameter int T_HZOE_PS    = 5000,
  parameter bit OE_LOW_WRITE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC  = mx(cyc(T_AA_PS), cyc(T_RC_PS));
  localparam int HZ_CYC  = cyc(T_HZWE_PS);
  localparam int SD_CYC  = cyc(T_SD_PS);
  localparam int WR_BASE = mx(mx(cyc(T_PWE_PS), cyc(T_AW_PS)), mx(SD_CYC, cyc(T_WC_PS)));
  localparam int WR_CYC  = OE_LOW_WRITE ? mx(WR_BASE, HZ_CYC + SD_CYC) : WR_BASE;
  localparam int TA_CYC  = cyc(T_HZOE_PS);
  localparam int MAXC    = mx(mx(RD_CYC, WR_CYC), TA_CYC);
  localparam int CW      = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_TURN, S_RD, S_WR} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] wd_q;
  logic          last_rd;
  wire           last = (cnt == CW'(1));

  assign mem_dq_out = wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      wd_q      <= '0;
      mem_addr  <= '0;
      rdata     <= '0;
      last_rd   <= 1'b0;
      done      <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          mem_addr <= req_addr;
          wd_q     <= req_wdata;
          if (!req_write) begin
            state    <= S_RD;
            cnt      <= CW'(RD_CYC);
            mem_ce_n <= 1'b0;
            mem_oe_n <= 1'b0;
          end else if (last_rd && !OE_LOW_WRITE) begin
            state <= S_TURN;
            cnt   <= CW'(TA_CYC);
          end else begin
            state     <= S_WR;
            cnt       <= CW'(WR_CYC);
            mem_ce_n  <= 1'b0;
            mem_we_n  <= 1'b0;
            mem_oe_n  <= !OE_LOW_WRITE;
            mem_dq_oe <= !OE_LOW_WRITE;
          end
        end
        S_TURN: begin
          if (last) begin
            state     <= S_WR;
            cnt       <= CW'(WR_CYC);
            mem_ce_n  <= 1'b0;
            mem_we_n  <= 1'b0;
            mem_dq_oe <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_RD: begin
          if (last) begin
            state    <= S_IDLE;
            rdata    <= mem_dq_in;
            done     <= 1'b1;
            last_rd  <= 1'b1;
            mem_ce_n <= 1'b1;
            mem_oe_n <= !OE_LOW_WRITE;
          end else cnt <= cnt - 1'b1;
        end
        default: begin
          if (last) begin
            state     <= S_IDLE;
            done      <= 1'b1;
            last_rd   <= 1'b0;
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(WR_CYC - HZ_CYC + 1)) mem_dq_oe <= 1'b1;
          end
        end
      endcase
    end
  end

  AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && !mem_we_n)); // R5
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n); // R3
  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && mem_we_n) |-> !mem_oe_n); // R2
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!OE_LOW_WRITE && $rose(mem_dq_oe)) |-> (mem_oe_n && $past(mem_oe_n))); // R4
  AST_HZ_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (OE_LOW_WRITE && $rose(mem_dq_oe)) |-> (!mem_we_n && $past(!mem_we_n))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R9

endmodule

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
module asram_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        sel = 1'b0;
  logic        start = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;

  logic        done0, ce0, oe0, we0, drv0, done1, ce1, oe1, we1, drv1;
  logic [3:0]  rd0, rd1, dqo0, dqo1, dqi0, dqi1;
  logic [19:0] ad0, ad1;
  logic [3:0]  mem0 [64];
  logic [3:0]  mem1 [64];

  asram_ctrl uut (.clk(clk), .rst_n(rst_n), .start(start && !sel), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done0), .rdata(rd0), .mem_addr(ad0),
    .mem_ce_n(ce0), .mem_oe_n(oe0), .mem_we_n(we0), .mem_dq_out(dqo0), .mem_dq_oe(drv0),
    .mem_dq_in(dqi0));

  asram_ctrl #(.OE_LOW_WRITE(1'b1)) uut_ol (.clk(clk), .rst_n(rst_n), .start(start && sel),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .done(done1), .rdata(rd1),
    .mem_addr(ad1), .mem_ce_n(ce1), .mem_oe_n(oe1), .mem_we_n(we1), .mem_dq_out(dqo1),
    .mem_dq_oe(drv1), .mem_dq_in(dqi1));

  assign dqi0 = (!ce0 && !oe0 && we0) ? mem0[ad0[5:0]] : 4'h0;
  assign dqi1 = (!ce1 && !oe1 && we1) ? mem1[ad1[5:0]] : 4'h0;

  initial for (int i = 0; i < 64; i++) begin
    mem0[i] = 4'(i + 3);
    mem1[i] = 4'(i + 3);
  end
  always @(posedge clk) begin
    if (!ce0 && !we0 && drv0) mem0[ad0[5:0]] <= dqo0;
    if (!ce1 && !we1 && drv1) mem1[ad1[5:0]] <= dqo1;
  end

  wire        s_done = sel ? done1 : done0;
  wire        s_ce = sel ? ce1 : ce0;
  wire        s_oe = sel ? oe1 : oe0;
  wire        s_we = sel ? we1 : we0;
  wire        s_drv = sel ? drv1 : drv0;
  wire [3:0]  s_rd = sel ? rd1 : rd0;
  wire [3:0]  s_dqo = sel ? dqo1 : dqo0;
  wire [19:0] s_ad = sel ? ad1 : ad0;

  int vectors = 0, errors = 0;
  bit finished = 0;
  int lat, nrd, nwe, ndrv, fdrv, noe_lo, nbad, npost;

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic op(input bit wr, input logic [19:0] a, input logic [3:0] d, input bit busy_poke);
    lat = 0; nrd = 0; nwe = 0; ndrv = 0; fdrv = 0; noe_lo = 0; nbad = 0; npost = 0;
    @(negedge clk);
    start = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1 && busy_poke) begin req_write = 1'b1; req_wdata = 4'hF; end
      else start = 1'b0;
      if (k == 2) start = 1'b0;
      if (!s_ce && !s_oe && s_we) nrd++;
      if (!s_we) nwe++;
      if (!s_oe) noe_lo++;
      if (s_drv) begin
        ndrv++;
        if (fdrv == 0) fdrv = k;
        if (s_dqo != d) nbad++;
        if (s_ce || s_we) nbad++;
      end
      if (!s_ce && s_ad != a) nbad++;
      if (s_done) begin lat = k; break; end
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (s_done || !s_ce || !s_we || s_drv) npost++;
    end
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1 strobes high uut", {31'b0, ce0 && oe0 && we0}, 1);
      check("R1 driver off/done low uut", {30'b0, drv0, done0}, 0);
      check("R1 strobes high uut_ol", {31'b0, ce1 && oe1 && we1 && !drv1 && !done1}, 1);
    end
  endtask

  task automatic t_write_idle();
    sel = 0; op(1'b1, 20'd3, 4'h9, 1'b0);
    check("R3 write latency", lat, 3);
    check("R3 we low cycles", nwe, 2);
    check("R3 driven cycles", ndrv, 2);
    check("R3 oe held high", noe_lo, 0);
    check("R5 R9 drive window/data/address", nbad, 0);
    check("R6 done single pulse", npost, 0);
  endtask

  task automatic t_read(input logic [19:0] a, input logic [3:0] exp, input string tag);
    op(1'b0, a, 4'h0, 1'b0);
    check({tag, " read latency"}, lat, 3);
    check({tag, " read strobe cycles"}, nrd, 2);
    check({tag, " read data"}, int'(s_rd), int'(exp));
    check({tag, " read no drive"}, ndrv + nbad + npost, 0);
  endtask

  task automatic t_write_after_read();
    sel = 0; op(1'b1, 20'd7, 4'hC, 1'b0);
    check("R4 write-after-read latency", lat, 4);
    check("R4 first driven cycle", fdrv, 2);
    check("R4 we low cycles", nwe, 2);
    check("R4 R5 drive window", nbad, 0);
    check("R6 rdata held across write", int'(s_rd), 9);
  endtask

  task automatic t_busy();
    sel = 0; op(1'b0, 20'd10, 4'h0, 1'b1);
    check("R7 read data with poke", int'(s_rd), 13);
    check("R7 no second access", npost, 0);
    t_read(20'd10, 4'hD, "R7 word untouched");
  endtask

  task automatic t_oe_low();
    sel = 1; t_read(20'd2, 4'h5, "R2 oe-low mode");
    op(1'b1, 20'd2, 4'h6, 1'b0);
    check("R8 write latency", lat, 3);
    check("R8 we low cycles", nwe, 2);
    check("R8 driven cycles", ndrv, 1);
    check("R8 first driven cycle", fdrv, 2);
    check("R8 oe low every cycle", noe_lo, 3);
    check("R8 R5 drive window", nbad + npost, 0);
    t_read(20'd2, 4'h6, "R8 readback");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_idle();
    sel = 0; t_read(20'd3, 4'h9, "R2");
    t_write_after_read();
    sel = 0; t_read(20'd7, 4'hC, "R3 R4 readback");
    t_busy();
    t_oe_low();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      vectors++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule